// File: doc/BRIEF.md
# Split Decade Counter with Preset

This block is a four-bit counter built from two sections that normally count on their own. The low section divides by two and drives `q_lo`. The high section divides by five, steps through `q_hi` = 0, 1, 2, 3, 4 and then returns to 0. Each section has its own advance strobe. An advance strobe is a single-cycle pulse that asks for one step on the next rising edge of the one system clock.

A two-bit `mode` input joins the sections in one of two ways. In one chaining the low section carries into the high section, which gives a plain BCD count from 0 to 9. In the other, the high section carries into the low section. That gives a bi-quinary count in which `q_lo` is a square wave at one tenth of the strobe rate.

Two gated control pairs act on both sections at once. When both inputs of the preset pair are high, the counter loads nine. When both inputs of the clear pair are high, it loads zero. The preset pair wins over the clear pair. Both pairs win over any advance strobe.

Top module: `split_decade_ctr`

## Requirements
- R1: While `rst` is high at a rising clock edge, `q_lo` and `q_hi` are 0 after that edge.
- R2: If `nine_a` and `nine_b` are both high at an edge, then after that edge `q_hi` = 3'b100 and `q_lo` = 1. This happens whatever the clear inputs, the strobes and `mode` hold.
- R3: If `clr_a` and `clr_b` are both high at an edge, and the preset pair is not both high, then both outputs are 0 after that edge. The strobes are ignored in that cycle.
- R4: If only one input of a pair is high, that pair has no effect. Counting goes on exactly as if both inputs of the pair were low.
- R5: When `mode` is 2'b00 or 2'b11, the sections run independently:
  - `adv_a` toggles `q_lo`.
  - `adv_b` moves `q_hi` to `(q_hi+1) mod 5`.
  - A section whose strobe is low holds its value.
- R6: When `mode` is 2'b01 (BCD), `adv_a` steps the value `2*q_hi + q_lo` to `(value+1) mod 10`. `adv_b` has no effect.
- R7: When `mode` is 2'b10 (bi-quinary), `adv_b` steps the value `5*q_lo + q_hi` to `(value+1) mod 10`. `q_lo` toggles exactly when `q_hi` wraps from 4 to 0. `adv_a` has no effect.
- R8: In bi-quinary mode, `q_lo` is high after exactly 10 of any 20 consecutive strobes that start from zero. It rises after the fifth strobe.
- R9: Every update, including the carry into a chained section, is visible after the same edge that samples the strobe. There is no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Chaining select: 00/11 independent, 01 BCD, 10 bi-quinary |
| adv_a | input | 1 | Advance strobe for the divide-by-two section |
| adv_b | input | 1 | Advance strobe for the divide-by-five section |
| clr_a | input | 1 | Clear pair, first input |
| clr_b | input | 1 | Clear pair, second input |
| nine_a | input | 1 | Preset-to-nine pair, first input |
| nine_b | input | 1 | Preset-to-nine pair, second input |
| q_lo | output | 1 | Divide-by-two section output |
| q_hi | output | 3 | Divide-by-five section value, 0 to 4 |

## Verification
Every result is due exactly one edge after the inputs that cause it. This covers reset, preset, clear, single-section steps and the carry into a chained section, because both sections are registered side by side and the carry is decided from their current values. The bench drives each input vector on a falling edge and lets one rising edge pass. It then compares the outputs at the next falling edge against an arithmetic model that it steps at that same rising edge, so a result arriving one cycle early or late fails. The sweep visits every mode with a mixture of strobes and partial or full control pairs. Directed runs cover the full BCD and bi-quinary sequences and the duty of `q_lo`.

// File: rtl/dc_pkg.sv
package dc_pkg;

  typedef enum logic [1:0] {
    CHAIN_SPLIT = 2'b00,
    CHAIN_BCD   = 2'b01,
    CHAIN_BIQ   = 2'b10,
    CHAIN_SPARE = 2'b11
  } chain_mode_t;

  typedef enum logic [1:0] {
    CTL_COUNT = 2'b00,
    CTL_CLEAR = 2'b01,
    CTL_NINE  = 2'b10
  } ctl_t;

endpackage

// File: rtl/dc_lo_stage.sv
module dc_lo_stage
  import dc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  ctl_t ctl,
  input  logic step,
  output logic q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= 1'b0;
    end else begin
      unique case (ctl)
        CTL_NINE:  q <= 1'b1;
        CTL_CLEAR: q <= 1'b0;
        default:   if (step) q <= ~q;
      endcase
    end
  end

endmodule

// File: rtl/dc_hi_stage.sv
module dc_hi_stage
  import dc_pkg::*;
#(
  parameter int MOD = 5,
  localparam int W = $clog2(MOD)
) (
  input  logic         clk,
  input  logic         rst,
  input  ctl_t         ctl,
  input  logic         step,
  output logic [W-1:0] q,
  output logic         at_top
);

  localparam logic [W-1:0] TOP = W'(MOD - 1);

  logic [W-1:0] q_next_cnt;

  // Codes at or beyond TOP return to zero, so an unused code recovers.
  always_comb begin
    if (q >= TOP) q_next_cnt = '0;
    else          q_next_cnt = q + W'(1);
  end

  assign at_top = (q >= TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      unique case (ctl)
        CTL_NINE:  q <= TOP;
        CTL_CLEAR: q <= '0;
        default:   if (step) q <= q_next_cnt;
      endcase
    end
  end

endmodule

// File: rtl/dc_chain.sv
module dc_chain
  import dc_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       adv_a,
  input  logic       adv_b,
  input  logic       lo_q,
  input  logic       hi_top,
  output logic       step_lo,
  output logic       step_hi
);

  chain_mode_t m;
  assign m = chain_mode_t'(mode);

  // A carry is taken when the feeding section is about to fall to zero.
  always_comb begin
    unique case (m)
      CHAIN_BCD: begin
        step_lo = adv_a;
        step_hi = adv_a & lo_q;
      end
      CHAIN_BIQ: begin
        step_hi = adv_b;
        step_lo = adv_b & hi_top;
      end
      default: begin
        step_lo = adv_a;
        step_hi = adv_b;
      end
    endcase
  end

endmodule

// File: rtl/split_decade_ctr.sv
module split_decade_ctr
  import dc_pkg::*;
#(
  parameter int HI_MOD = 5,
  localparam int HI_W = $clog2(HI_MOD)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      mode,
  input  logic            adv_a,
  input  logic            adv_b,
  input  logic            clr_a,
  input  logic            clr_b,
  input  logic            nine_a,
  input  logic            nine_b,
  output logic            q_lo,
  output logic [HI_W-1:0] q_hi
);

  ctl_t ctl;
  logic step_lo, step_hi, hi_top;

  // Preset outranks clear; both outrank counting.
  always_comb begin
    if (nine_a & nine_b)     ctl = CTL_NINE;
    else if (clr_a & clr_b)  ctl = CTL_CLEAR;
    else                     ctl = CTL_COUNT;
  end

  dc_chain chain_i (
    .mode    (mode),
    .adv_a   (adv_a),
    .adv_b   (adv_b),
    .lo_q    (q_lo),
    .hi_top  (hi_top),
    .step_lo (step_lo),
    .step_hi (step_hi)
  );

  dc_lo_stage lo_i (
    .clk  (clk),
    .rst  (rst),
    .ctl  (ctl),
    .step (step_lo),
    .q    (q_lo)
  );

  dc_hi_stage #(.MOD(HI_MOD)) hi_i (
    .clk    (clk),
    .rst    (rst),
    .ctl    (ctl),
    .step   (step_hi),
    .q      (q_hi),
    .at_top (hi_top)
  );

endmodule

// File: rtl/dc_checker.sv
module dc_checker #(
  parameter int HI_MOD = 5,
  localparam int HI_W = $clog2(HI_MOD)
) (
  input logic            clk,
  input logic            rst,
  input logic [1:0]      mode,
  input logic            adv_a,
  input logic            adv_b,
  input logic            clr_a,
  input logic            clr_b,
  input logic            nine_a,
  input logic            nine_b,
  input logic            q_lo,
  input logic [HI_W-1:0] q_hi
);

  localparam logic [HI_W-1:0] TOP = HI_W'(HI_MOD - 1);

  logic idle;
  assign idle = !(nine_a && nine_b) && !(clr_a && clr_b);

  a_r1_reset: assert property (@(posedge clk)
    rst |=> (q_lo == 1'b0 && q_hi == '0));

  a_r2_nine: assert property (@(posedge clk) disable iff (rst)
    (nine_a && nine_b) |=> (q_lo == 1'b1 && q_hi == TOP));

  a_r3_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_a && clr_b && !(nine_a && nine_b)) |=> (q_lo == 1'b0 && q_hi == '0));

  a_r5_range: assert property (@(posedge clk) disable iff (rst)
    q_hi <= TOP);

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (idle && !adv_a && !adv_b) |=> ($stable(q_lo) && $stable(q_hi)));

  a_r6_bcd_wrap: assert property (@(posedge clk) disable iff (rst)
    (idle && mode == 2'b01 && adv_a && q_lo && q_hi == TOP)
      |=> (q_lo == 1'b0 && q_hi == '0));

  a_r7_biq_up: assert property (@(posedge clk) disable iff (rst)
    (idle && mode == 2'b10 && adv_b && q_hi == TOP && !q_lo)
      |=> (q_lo == 1'b1 && q_hi == '0));

  a_r7_biq_down: assert property (@(posedge clk) disable iff (rst)
    (idle && mode == 2'b10 && adv_b && q_hi == TOP && q_lo)
      |=> (q_lo == 1'b0 && q_hi == '0));

endmodule

bind split_decade_ctr dc_checker #(.HI_MOD(HI_MOD)) chk_i (.*);

// File: tb/split_decade_ctr_tb.sv
module split_decade_ctr_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'b00;
  logic       adv_a = 1'b0, adv_b = 1'b0;
  logic       clr_a = 1'b0, clr_b = 1'b0;
  logic       nine_a = 1'b0, nine_b = 1'b0;
  logic       q_lo;
  logic [2:0] q_hi;

  int total = 0;
  int bad = 0;
  int exp_lo = 0;
  int exp_hi = 0;
  bit done = 0;

  always #2 clk = ~clk;

  split_decade_ctr dut_i (
    .clk(clk), .rst(rst), .mode(mode), .adv_a(adv_a), .adv_b(adv_b),
    .clr_a(clr_a), .clr_b(clr_b), .nine_a(nine_a), .nine_b(nine_b),
    .q_lo(q_lo), .q_hi(q_hi)
  );

  task automatic check(input string tag);
    total++;
    if (q_lo !== exp_lo[0] || q_hi !== exp_hi[2:0]) begin
      bad++;
      $display("FAIL %s: got lo=%0d hi=%0d expected lo=%0d hi=%0d",
               tag, q_lo, q_hi, exp_lo, exp_hi);
    end
  endtask

  // Arithmetic model of one edge.
  task automatic model_step();
    int v;
    if (rst) begin
      exp_lo = 0; exp_hi = 0;
    end else if (nine_a && nine_b) begin
      exp_lo = 1; exp_hi = 4;
    end else if (clr_a && clr_b) begin
      exp_lo = 0; exp_hi = 0;
    end else if (mode == 2'b01) begin
      if (adv_a) begin
        v = (2 * exp_hi + exp_lo + 1) % 10;
        exp_lo = v % 2; exp_hi = v / 2;
      end
    end else if (mode == 2'b10) begin
      if (adv_b) begin
        v = (5 * exp_lo + exp_hi + 1) % 10;
        exp_lo = v / 5; exp_hi = v % 5;
      end
    end else begin
      if (adv_a) exp_lo = 1 - exp_lo;
      if (adv_b) exp_hi = (exp_hi + 1) % 5;
    end
  endtask

  // Inputs are set at a falling edge; one rising edge; compare at next falling edge.
  task automatic cyc(input string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(tag);
  endtask

  task automatic quiet();
    adv_a = 0; adv_b = 0; clr_a = 0; clr_b = 0; nine_a = 0; nine_b = 0;
  endtask

  initial begin
    int hi_cnt;
    string tag;
    quiet();
    rst = 1;
    @(negedge clk);
    cyc("R1 reset");
    rst = 0;

    // R5: independent sections, both strobes
    mode = 2'b00;
    for (int i = 0; i < 12; i++) begin
      adv_a = i[0]; adv_b = 1;
      cyc("R5 split count");
    end
    quiet();

    // R6: full BCD run from zero, 12 strobes, adv_b also pulsed (ignored)
    clr_a = 1; clr_b = 1; cyc("R3 clear");
    quiet(); mode = 2'b01;
    for (int i = 0; i < 12; i++) begin
      adv_a = 1; adv_b = 0; cyc("R6/R9 bcd step");
      adv_a = 0; adv_b = 1; cyc("R6 adv_b ignored");
    end
    quiet();

    // R7/R8: bi-quinary run, 20 strobes, count high q_lo
    clr_a = 1; clr_b = 1; cyc("R3 clear");
    quiet(); mode = 2'b10;
    hi_cnt = 0;
    for (int i = 1; i <= 20; i++) begin
      adv_b = 1; adv_a = 1; cyc("R7/R9 biq step");
      if (q_lo) hi_cnt++;
      total++;
      if (q_lo !== (((i % 10) >= 5) ? 1'b1 : 1'b0)) begin
        bad++;
        $display("FAIL R8 strobe %0d: got lo=%0d expected lo=%0d",
                 i, q_lo, ((i % 10) >= 5));
      end
    end
    total++;
    if (hi_cnt != 10) begin
      bad++;
      $display("FAIL R8 duty: got %0d expected 10", hi_cnt);
    end
    quiet();

    // R2: preset wins over clear and strobes
    adv_a = 1; adv_b = 1; clr_a = 1; clr_b = 1; nine_a = 1; nine_b = 1;
    cyc("R2 nine over clear");
    quiet();

    // Sweep all modes with mixed control and strobes
    for (int m = 0; m < 4; m++) begin
      mode = 2'(m);
      for (int i = 0; i < 256; i++) begin
        adv_a = i[0]; adv_b = i[1];
        clr_a = i[2]; clr_b = i[3] & i[4];
        nine_a = i[5]; nine_b = i[6] & i[7];
        if (nine_a && nine_b) tag = "R2";
        else if (clr_a && clr_b) tag = "R3";
        else if (clr_a || clr_b || nine_a || nine_b) tag = "R4";
        else if (m == 1) tag = "R6";
        else if (m == 2) tag = "R7";
        else tag = "R5";
        cyc({tag, " sweep R9"});
      end
    end
    quiet();

    // R1: reset in mid-run
    nine_a = 1; nine_b = 1; cyc("R2 preset");
    quiet(); rst = 1; adv_a = 1; adv_b = 1;
    cyc("R1 reset mid-run");
    rst = 0; quiet();
    cyc("R1 hold after reset");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule